// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block keeps the eight status flags of an asynchronous serial port. The transmitter and the receiver report events to it as single-cycle pulses. The block latches those events into flags and shows them together as one read-only status byte. The shift registers, baud timing and line sampling sit outside it.

A flag is cleared by a two-step acknowledge. A status read takes a snapshot of the flags that are set at that moment and arms them. The next access to the shared data register then clears those armed flags. A write clears the armed transmit-side flags, and a read clears the armed receive-side flags. That first data access drops the whole arm set.

The line-idle flag has extra rules. It sets only after the receive line has been seen active and then goes idle. It is held clear while receiver wakeup mode is on.

Top module: `sps_flag_unit`

## Requirements
- R1: After reset `status_q` reads 8'hC0. Bit 7 is transmit-ready and bit 6 is transmit-done; both are 1. All other bits are 0.
- R2: A pulse on an event input sets its bit on the next clock edge. The bits are: `tx_ready_pulse`=7, `tx_done_pulse`=6, `rx_char_pulse`=5, `rx_overrun_pulse`=3, `rx_noise_pulse`=2, `rx_frame_err_pulse`=1, `rx_parity_err_pulse`=0.
- R3: `data_wr` clears bits 7 and 6, but only those that a `stat_rd` strobe saw set at an earlier clock edge, with no data access between that read and the write.
- R4: `data_rd` clears bits 5 to 0 under the same arming rule as R3.
- R5: A data register access with no arming status read before it leaves `status_q` unchanged.
- R6: Both of the following stay set when the next data access arrives:
  - a flag set after the status read that armed the others;
  - any flag, once a data access has already used up the arm set.
- R7: If a set pulse and a clearing access reach the same flag in the same cycle, the flag stays set.
- R8: `data_wr` never clears bits 5 to 0, and `data_rd` never clears bits 7 and 6.
- R9: Bit 4 (line idle) sets only when `rx_line_idle` is 1 after the line was seen active (`rx_line_idle`=0) since reset or since the last time the flag set. It clears with a status read followed by `data_rd`. It then stays clear while the line remains idle.
- R10: While `wakeup_mode` is 1, bit 4 is forced to 0 on the next edge and cannot set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ready_pulse | input | 1 | Data register can take a new character |
| tx_done_pulse | input | 1 | Transmitter has nothing in progress |
| rx_char_pulse | input | 1 | Received character ready |
| rx_overrun_pulse | input | 1 | Receive overrun event |
| rx_noise_pulse | input | 1 | Noise seen on a received character |
| rx_frame_err_pulse | input | 1 | Stop bit error |
| rx_parity_err_pulse | input | 1 | Parity mismatch |
| rx_line_idle | input | 1 | Receive line currently idle (level) |
| wakeup_mode | input | 1 | Receiver wakeup mode enabled |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| status_q | output | 8 | Status flags |

## Verification
A wrong arm set would show at the ports on the first data access after the status read. Either a flag that should stay up falls, or a flag that was acknowledged stays up. A wrong idle re-arm state would show as bit 4 rising with no line activity in between, or failing to rise after activity, one cycle after the line goes idle. The bench runs a reference model alongside the design and compares the full status byte on every cycle. Any such fault is therefore caught on the first cycle it reaches the output.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int NFLAG = 8;
  typedef logic [NFLAG-1:0] flag_vec_t;

  localparam int B_TXR = 7;
  localparam int B_TXD = 6;
  localparam int B_RXC = 5;
  localparam int B_IDL = 4;
  localparam int B_OVR = 3;
  localparam int B_NSE = 2;
  localparam int B_FRM = 1;
  localparam int B_PAR = 0;

  localparam flag_vec_t RESET_FLAGS = 8'hC0;
  localparam flag_vec_t TX_GROUP    = 8'hC0;
  localparam flag_vec_t RX_GROUP    = ~TX_GROUP;

  // flags an access is allowed to clear, given the armed snapshot
  function automatic flag_vec_t clear_vec(flag_vec_t armed, logic wr, logic rd);
    flag_vec_t grp;
    grp = (wr ? TX_GROUP : '0) | (rd ? RX_GROUP : '0);
    return armed & grp;
  endfunction

  // set has priority over clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/sps_arm_tracker.sv
module sps_arm_tracker
  import sps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_rd,
  input  logic      data_access,
  input  flag_vec_t flags,
  output flag_vec_t arm_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)           arm_q <= '0;
    else if (stat_rd)     arm_q <= flags;
    else if (data_access) arm_q <= '0;
  end
endmodule

// File: rtl/sps_idle_detect.sv
module sps_idle_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line_idle,
  input  logic wake,
  output logic idle_set
);
  logic primed_q;

  assign idle_set = line_idle & primed_q & ~wake;

  always_ff @(posedge clk) begin
    if (!rst_n)          primed_q <= 1'b0;
    else if (!line_idle) primed_q <= 1'b1;
    else if (idle_set)   primed_q <= 1'b0;
  end
endmodule

// File: rtl/sps_flag_bank.sv
module sps_flag_bank
  import sps_pkg::*;
#(
  parameter int        HOLD_BIT = B_IDL,
  parameter flag_vec_t RST_VAL  = RESET_FLAGS
) (
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  input  logic      hold_clear,
  output flag_vec_t flags_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i == HOLD_BIT) begin : g_held
      always_ff @(posedge clk) begin
        if (!rst_n)          flags_q[i] <= RST_VAL[i];
        else if (hold_clear) flags_q[i] <= 1'b0;
        else                 flags_q[i] <= flag_next(flags_q[i], set_vec[i], clr_vec[i]);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) flags_q[i] <= RST_VAL[i];
        else        flags_q[i] <= flag_next(flags_q[i], set_vec[i], clr_vec[i]);
      end
    end
  end
endmodule

// File: rtl/sps_flag_unit.sv
module sps_flag_unit
  import sps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_ready_pulse,
  input  logic       tx_done_pulse,
  input  logic       rx_char_pulse,
  input  logic       rx_overrun_pulse,
  input  logic       rx_noise_pulse,
  input  logic       rx_frame_err_pulse,
  input  logic       rx_parity_err_pulse,
  input  logic       rx_line_idle,
  input  logic       wakeup_mode,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       data_wr,
  output logic [7:0] status_q
);
  flag_vec_t flags;
  flag_vec_t arm_mask;
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  logic      idle_set;
  logic      data_access;

  assign data_access = data_rd | data_wr;

  always_comb begin
    set_vec        = '0;
    set_vec[B_TXR] = tx_ready_pulse;
    set_vec[B_TXD] = tx_done_pulse;
    set_vec[B_RXC] = rx_char_pulse;
    set_vec[B_IDL] = idle_set;
    set_vec[B_OVR] = rx_overrun_pulse;
    set_vec[B_NSE] = rx_noise_pulse;
    set_vec[B_FRM] = rx_frame_err_pulse;
    set_vec[B_PAR] = rx_parity_err_pulse;
  end

  assign clr_vec = clear_vec(arm_mask, data_wr, data_rd);

  sps_idle_detect u_idle (
    .clk(clk), .rst_n(rst_n), .line_idle(rx_line_idle),
    .wake(wakeup_mode), .idle_set(idle_set)
  );

  sps_arm_tracker u_arm (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd),
    .data_access(data_access), .flags(flags), .arm_q(arm_mask)
  );

  sps_flag_bank #(.HOLD_BIT(B_IDL), .RST_VAL(RESET_FLAGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .hold_clear(wakeup_mode), .flags_q(flags)
  );

  assign status_q = flags;
endmodule

// File: rtl/sps_flag_checker.sv
module sps_flag_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status_q,
  input logic [7:0] set_vec,
  input logic [7:0] arm_mask,
  input logic       stat_rd,
  input logic       data_rd,
  input logic       data_wr,
  input logic       rx_line_idle,
  input logic       wakeup_mode
);
  AST_SET_REACHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & 8'hEF) != 8'h00) |=> ((status_q & $past(set_vec) & 8'hEF) == ($past(set_vec) & 8'hEF))); // R2

  AST_NO_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(arm_mask) & 8'hEF) == 8'h00)); // R5

  AST_TX_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> ((status_q[7:6] & $past(status_q[7:6])) == $past(status_q[7:6]))); // R8

  AST_RX_ONLY_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> ((status_q & $past(status_q) & 8'h2F) == ($past(status_q) & 8'h2F))); // R8

  AST_ARM_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_rd || data_wr) && !stat_rd) |=> (arm_mask == 8'h00)); // R6

  AST_WAKE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup_mode |=> !status_q[4]); // R10

  AST_IDLE_NEEDS_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[4]) |-> $past(rx_line_idle)); // R9
endmodule

bind sps_flag_unit sps_flag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .set_vec(set_vec),
  .arm_mask(arm_mask), .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
  .rx_line_idle(rx_line_idle), .wakeup_mode(wakeup_mode)
);

// File: tb/test_sps_flag_unit.sv
module test_sps_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev = 8'h00;  // index = status bit; bit 4 unused
  logic line_idle = 1'b1, wake = 1'b0, srd = 1'b0, drd = 1'b0, dwr = 1'b0;
  logic [7:0] status_q;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sps_flag_unit i_sps_flag_unit (
    .clk(clk), .rst_n(rst_n),
    .tx_ready_pulse(ev[7]), .tx_done_pulse(ev[6]), .rx_char_pulse(ev[5]),
    .rx_overrun_pulse(ev[3]), .rx_noise_pulse(ev[2]),
    .rx_frame_err_pulse(ev[1]), .rx_parity_err_pulse(ev[0]),
    .rx_line_idle(line_idle), .wakeup_mode(wake),
    .stat_rd(srd), .data_rd(drd), .data_wr(dwr), .status_q(status_q)
  );

  // reference model, held as separate bits
  bit mf[8];
  bit ma[8];
  bit seen_active;

  always @(posedge clk) begin
    bit nf[8];
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin mf[k] = (k >= 6); ma[k] = 0; end
      seen_active = 0;
    end else begin
      for (int k = 0; k < 8; k++) begin
        nf[k] = mf[k];
        if (ma[k] && ((k >= 6) ? dwr : drd)) nf[k] = 0;
        if (k != 4 && ev[k]) nf[k] = 1;
      end
      if (!line_idle) seen_active = 1;
      else if (seen_active && !wake) begin nf[4] = 1; seen_active = 0; end
      if (wake) nf[4] = 0;
      for (int k = 0; k < 8; k++) begin
        if (srd) ma[k] = mf[k];
        else if (drd || dwr) ma[k] = 0;
      end
      for (int k = 0; k < 8; k++) mf[k] = nf[k];
    end
  end

  function automatic logic [7:0] model_byte();
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = mf[k];
    return b;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) if (rst_n) check(cur_req, status_q, model_byte());

  task automatic cyc(logic [7:0] e, logic s, logic r, logic w);
    @(negedge clk);
    ev = e; srd = s; drd = r; dwr = w;
    @(negedge clk);
    ev = 8'h00; srd = 0; drd = 0; dwr = 0;
  endtask

  task automatic directed(string req, logic [7:0] exp);
    @(negedge clk); #1;
    check(req, status_q, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    directed("R1", 8'hC0);
    // R2: each event sets its own bit
    cur_req = "R2";
    cyc(8'h20, 0, 0, 0); cyc(8'h08, 0, 0, 0); cyc(8'h04, 0, 0, 0);
    cyc(8'h02, 0, 0, 0); cyc(8'h01, 0, 0, 0);
    directed("R2", 8'hEF);
    // R5: unarmed accesses clear nothing
    cur_req = "R5";
    cyc(8'h00, 0, 1, 0); cyc(8'h00, 0, 0, 1);
    directed("R5", 8'hEF);
    // R4: status read then data read clears receive side
    cur_req = "R4";
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 1, 0);
    directed("R4", 8'hC0);
    // R3: status read then data write clears transmit side
    cur_req = "R3";
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 0, 1);
    directed("R3", 8'h00);
    cyc(8'hC0, 0, 0, 0);
    directed("R3", 8'hC0);
    // R8: a write leaves rx flags, a read leaves tx flags
    cur_req = "R8";
    cyc(8'h21, 0, 0, 0);
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 0, 1);
    directed("R8", 8'h21);
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 1, 0);
    directed("R8", 8'h00);
    cyc(8'hC0, 0, 0, 0);
    // R6: arm set spent by the first access, late flags not armed
    cur_req = "R6";
    cyc(8'h24, 0, 0, 0);
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 0, 1); cyc(8'h00, 0, 1, 0);
    directed("R6", 8'h24);
    cyc(8'h00, 1, 0, 0); cyc(8'h08, 0, 0, 0); cyc(8'h00, 0, 1, 0);
    directed("R6", 8'h08);
    // R7: set and clear in the same cycle, set wins
    cur_req = "R7";
    cyc(8'h00, 1, 0, 0); cyc(8'h08, 0, 1, 0);
    directed("R7", 8'h08);
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 1, 0);
    directed("R7", 8'h00);
    // R9: idle needs activity first, then once per activity
    cur_req = "R9";
    repeat (3) cyc(8'h00, 0, 0, 0);
    directed("R9", 8'h00);
    @(negedge clk); line_idle = 0;
    @(negedge clk); @(negedge clk); line_idle = 1;
    @(negedge clk); #1; check("R9", status_q, 8'h10);
    cyc(8'h00, 1, 0, 0); cyc(8'h00, 0, 1, 0);
    repeat (3) cyc(8'h00, 0, 0, 0);
    directed("R9", 8'h00);
    @(negedge clk); line_idle = 0;
    @(negedge clk); line_idle = 1;
    @(negedge clk); #1; check("R9", status_q, 8'h10);
    // R10: wakeup mode forces the idle flag low and blocks it
    cur_req = "R10";
    @(negedge clk); wake = 1;
    @(negedge clk); #1; check("R10", status_q, 8'h00);
    @(negedge clk); line_idle = 0;
    @(negedge clk); line_idle = 1;
    repeat (3) @(negedge clk);
    #1; check("R10", status_q, 8'h00);
    @(negedge clk); wake = 0;
    @(negedge clk); #1; check("R10", status_q, 8'h10);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule